// File: doc/BRIEF.md
# Dual-Pulse Presettable Up/Down Counter

This block is one digit of a counter with two count-pulse inputs. A rising edge on the up input adds one to the count, and a rising edge on the down input takes one away. A parameter sets the counting mode. In binary mode the digit counts modulo 2^WIDTH, which is 0 to 15 at the default width. In decade mode it runs through 0 to 9 in plain 8421 code. A parallel load is active low and copies a preset word into the digit. A master clear is active high and zeroes it. Both act at once, without waiting for any clock edge.

Two active-low terminal outputs let digits be chained with no glue logic. The carry output goes to the up input of the next digit, and the borrow output goes to its down input. Carry is low only while the digit sits at its top value and the up input is low. Its rising edge therefore comes with the up pulse that wraps the digit back to zero. Borrow does the same thing at zero for the down direction.

The block runs on one free-running system clock. Each count-pulse input passes through its own two-flop synchronizer, and the digit steps when a rising edge is detected there.

Top module: `dual_pulse_updown_counter`

## Requirements
- R1: In binary mode an up step adds one to the count, and 15 steps to 0.
- R2: In binary mode a down step takes one from the count, and 0 steps to 15.
- R3: A rising edge on a count-pulse input changes the count at the third rising system-clock edge after the input rises. Falling edges and steady levels leave the count unchanged.
- R4: When both count-pulse inputs rise and are detected in the same system-clock cycle, the count holds.
- R5: In decade mode the count follows 0 to 9. Up from 9 gives 0, and down from 0 gives 9.
- R6: In decade mode a count of 10 to 15 goes to 0 on an up step. On a down step it drops by one.
- R7: carryN is low exactly while the count equals the top value (9 in decade mode, 15 in binary mode) and the synchronized up input is low. It returns high with the up pulse that wraps the count, one system clock before the count becomes 0.
- R8: borrowN is low exactly while the count is 0 and the synchronized down input is low. It returns high one system clock before a down step wraps the count to the top value.
- R9: Driving loadN low puts presetIn on countOut at once, without a system-clock edge. While loadN stays low, count pulses are ignored.
- R10: Driving masterClr high (active high) clears countOut to 0 at once and resets both synchronizers to the idle-high level. It overrides loadN.
- R11: Two decade digits form a two-digit counter 00 to 99 when the lower digit's carryN drives the upper digit's upPulse and its borrowN drives the upper digit's downPulse. Up from 99 gives 00, and down from 00 gives 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | Free-running system clock |
| masterClr | input | 1 | Asynchronous clear, active high |
| loadN | input | 1 | Asynchronous parallel load, active low |
| presetIn | input | WIDTH | Value taken in by the load |
| upPulse | input | 1 | Count-up pulse; idles high, counts on its rising edge |
| downPulse | input | 1 | Count-down pulse; idles high, counts on its rising edge |
| countOut | output | WIDTH | Present count |
| carryN | output | 1 | Terminal count up, active low |
| borrowN | output | 1 | Terminal count down, active low |

## Verification
The bench uses the default WIDTH of 4 and the default two-stage synchronizer. Two instances are built in decade mode and chained through carry and borrow. This covers the 99-to-00 and 00-to-99 wraps, the out-of-range presets 10 to 15, and the rule that a digit which is not at its top value must not ripple into the next one. A third instance in binary mode covers the 15/0 wraps, the exact synchronizer latency and the case where both inputs rise together.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic {
    MODE_BINARY = 1'b0,
    MODE_DECADE = 1'b1
  } count_mode_e;

  // strobes from the pulse control to the count path
  typedef struct packed {
    logic incr;    // detected up edge, down edge absent
    logic decr;    // detected down edge, up edge absent
    logic upHigh;  // synchronized level of the up input
    logic dnHigh;  // synchronized level of the down input
  } step_strobe_t;

  function automatic int unsigned top_value(count_mode_e mode, int unsigned width);
    return (mode == MODE_DECADE) ? 9 : ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/dpc_edge_sync.sv
module dpc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic sysClk,
  input  logic masterClr,
  input  logic pulseIn,
  output logic levelOut,
  output logic riseOut
);

  logic [STAGES-1:0] chain;
  logic              prevQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge sysClk or posedge masterClr) begin
        if (masterClr) chain <= '1;
        else           chain <= pulseIn;
      end
    end else begin : g_multi
      always_ff @(posedge sysClk or posedge masterClr) begin
        if (masterClr) chain <= '1;
        else           chain <= {chain[STAGES-2:0], pulseIn};
      end
    end
  endgenerate

  always_ff @(posedge sysClk or posedge masterClr) begin
    if (masterClr) prevQ <= 1'b1;
    else           prevQ <= chain[STAGES-1];
  end

  assign levelOut = chain[STAGES-1];
  assign riseOut  = chain[STAGES-1] & ~prevQ;

endmodule

// File: rtl/dpc_pulse_ctrl.sv
module dpc_pulse_ctrl #(
  parameter int unsigned STAGES = 2
) (
  input  logic                 sysClk,
  input  logic                 masterClr,
  input  logic                 upPulse,
  input  logic                 downPulse,
  output dpc_pkg::step_strobe_t stb
);

  logic upLvl, upRise, dnLvl, dnRise;

  dpc_edge_sync #(.STAGES(STAGES)) upSync (
    .sysClk   (sysClk),
    .masterClr(masterClr),
    .pulseIn  (upPulse),
    .levelOut (upLvl),
    .riseOut  (upRise)
  );

  dpc_edge_sync #(.STAGES(STAGES)) dnSync (
    .sysClk   (sysClk),
    .masterClr(masterClr),
    .pulseIn  (downPulse),
    .levelOut (dnLvl),
    .riseOut  (dnRise)
  );

  // coincident edges cancel (R4)
  always_comb begin
    stb.incr   = upRise & ~dnRise;
    stb.decr   = dnRise & ~upRise;
    stb.upHigh = upLvl;
    stb.dnHigh = dnLvl;
  end

endmodule

// File: rtl/dpc_count_path.sv
module dpc_count_path #(
  parameter int unsigned          WIDTH = 4,
  parameter dpc_pkg::count_mode_e MODE  = dpc_pkg::MODE_BINARY
) (
  input  logic                  sysClk,
  input  logic                  masterClr,
  input  logic                  loadN,
  input  logic [WIDTH-1:0]      presetIn,
  input  dpc_pkg::step_strobe_t stb,
  output logic [WIDTH-1:0]      countOut,
  output logic                  carryN,
  output logic                  borrowN
);

  localparam int unsigned      TOPV = dpc_pkg::top_value(MODE, WIDTH);
  localparam logic [WIDTH-1:0] MAXV = WIDTH'(TOPV);

  logic [WIDTH-1:0] cntQ, nextUp, nextDn;

  always_comb begin
    nextUp = (cntQ >= MAXV) ? '0 : cntQ + 1'b1;
    nextDn = (cntQ == '0) ? MAXV : cntQ - 1'b1;
  end

  // clear over load over counting; clear and load are asynchronous
  always_ff @(posedge sysClk or posedge masterClr or negedge loadN) begin
    if (masterClr)     cntQ <= '0;
    else if (!loadN)   cntQ <= presetIn;
    else if (stb.incr) cntQ <= nextUp;
    else if (stb.decr) cntQ <= nextDn;
  end

  assign countOut = cntQ;
  assign carryN   = ~((cntQ == MAXV) & ~stb.upHigh);
  assign borrowN  = ~((cntQ == '0) & ~stb.dnHigh);

  assert_clear_R10: assert property (@(posedge sysClk)
    masterClr |-> cntQ == '0);

  assert_load_R9: assert property (@(posedge sysClk) disable iff (masterClr)
    (!loadN && !$past(masterClr) && $stable(presetIn)) |-> cntQ == presetIn);

  assert_hold_idle_R3: assert property (@(posedge sysClk) disable iff (masterClr)
    (loadN && !stb.incr && !stb.decr) |=> ($stable(cntQ) || !loadN));

  assert_up_wrap_R5: assert property (@(posedge sysClk) disable iff (masterClr)
    (loadN && stb.incr && cntQ >= MAXV) |=> (cntQ == '0 || !loadN));

  assert_down_wrap_R2: assert property (@(posedge sysClk) disable iff (masterClr)
    (loadN && stb.decr && cntQ == '0) |=> (cntQ == MAXV || !loadN));

  assert_carry_edge_R7: assert property (@(posedge sysClk) disable iff (masterClr)
    ($rose(carryN) && $stable(cntQ) && stb.incr && loadN) |=> (cntQ == '0 || !loadN));

  assert_borrow_edge_R8: assert property (@(posedge sysClk) disable iff (masterClr)
    ($rose(borrowN) && $stable(cntQ) && stb.decr && loadN) |=> (cntQ == MAXV || !loadN));

endmodule

// File: rtl/dual_pulse_updown_counter.sv
module dual_pulse_updown_counter #(
  parameter int unsigned          WIDTH       = 4,
  parameter dpc_pkg::count_mode_e MODE        = dpc_pkg::MODE_BINARY,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic             sysClk,
  input  logic             masterClr,
  input  logic             loadN,
  input  logic [WIDTH-1:0] presetIn,
  input  logic             upPulse,
  input  logic             downPulse,
  output logic [WIDTH-1:0] countOut,
  output logic             carryN,
  output logic             borrowN
);

  dpc_pkg::step_strobe_t stb;

  dpc_pulse_ctrl #(.STAGES(SYNC_STAGES)) ctrl (
    .sysClk   (sysClk),
    .masterClr(masterClr),
    .upPulse  (upPulse),
    .downPulse(downPulse),
    .stb      (stb)
  );

  dpc_count_path #(.WIDTH(WIDTH), .MODE(MODE)) path (
    .sysClk   (sysClk),
    .masterClr(masterClr),
    .loadN    (loadN),
    .presetIn (presetIn),
    .stb      (stb),
    .countOut (countOut),
    .carryN   (carryN),
    .borrowN  (borrowN)
  );

endmodule

// File: tb/tb_dual_pulse_updown_counter.sv
module tb_dual_pulse_updown_counter;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       clr = 1'b1, loadN = 1'b1, upLo = 1'b1, dnLo = 1'b1;
  logic       binClr = 1'b1, binLoadN = 1'b1, upBin = 1'b1, dnBin = 1'b1;
  logic [3:0] preLo = 4'd0, preHi = 4'd0, preBin = 4'd0;
  logic [3:0] cntLo, cntHi, cntBin;
  logic       cLo, bLo, cHi, bHi, cBin, bBin;

  int total = 0, bad = 0;

  // lower decade digit
  dual_pulse_updown_counter #(.WIDTH(4), .MODE(dpc_pkg::MODE_DECADE)) dut (
    .sysClk(clk), .masterClr(clr), .loadN(loadN), .presetIn(preLo),
    .upPulse(upLo), .downPulse(dnLo), .countOut(cntLo), .carryN(cLo), .borrowN(bLo));

  // upper decade digit, clocked by the lower digit's terminal outputs (R11)
  dual_pulse_updown_counter #(.WIDTH(4), .MODE(dpc_pkg::MODE_DECADE)) dutHi (
    .sysClk(clk), .masterClr(clr), .loadN(loadN), .presetIn(preHi),
    .upPulse(cLo), .downPulse(bLo), .countOut(cntHi), .carryN(cHi), .borrowN(bHi));

  // stand-alone binary digit
  dual_pulse_updown_counter #(.WIDTH(4), .MODE(dpc_pkg::MODE_BINARY)) dutBin (
    .sysClk(clk), .masterClr(binClr), .loadN(binLoadN), .presetIn(preBin),
    .upPulse(upBin), .downPulse(dnBin), .countOut(cntBin), .carryN(cBin), .borrowN(bBin));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference (index 0 low, 1 high, 2 binary)
  int       mVal[3]    = '{0, 0, 0};
  int       mTop[3]    = '{9, 9, 15};
  logic [2:0] mUpH[3]  = '{3'b111, 3'b111, 3'b111};
  logic [2:0] mDnH[3]  = '{3'b111, 3'b111, 3'b111};
  logic     mCarry[3]  = '{1'b1, 1'b1, 1'b1};
  logic     mBorrow[3] = '{1'b1, 1'b1, 1'b1};

  always @(posedge clk) begin
    logic rawU[3], rawD[3];
    logic cl, ld, ru, rd;
    int   pre;
    rawU[0] = upLo;       rawD[0] = dnLo;
    rawU[1] = mCarry[0];  rawD[1] = mBorrow[0];
    rawU[2] = upBin;      rawD[2] = dnBin;
    for (int s = 0; s < 3; s++) begin
      cl  = (s == 2) ? binClr : clr;
      ld  = (s == 2) ? binLoadN : loadN;
      pre = (s == 0) ? int'(preLo) : (s == 1) ? int'(preHi) : int'(preBin);
      if (cl) begin
        mVal[s] = 0;
        mUpH[s] = 3'b111;
        mDnH[s] = 3'b111;
      end else begin
        ru = mUpH[s][1] & ~mUpH[s][2];
        rd = mDnH[s][1] & ~mDnH[s][2];
        if (!ld) mVal[s] = pre;
        else if (ru && !rd) mVal[s] = (mVal[s] >= mTop[s]) ? 0 : mVal[s] + 1;
        else if (rd && !ru) mVal[s] = (mVal[s] == 0) ? mTop[s] : mVal[s] - 1;
        mUpH[s] = {mUpH[s][1:0], rawU[s]};
        mDnH[s] = {mDnH[s][1:0], rawD[s]};
      end
      mCarry[s]  = !(mVal[s] == mTop[s] && !mUpH[s][1]);
      mBorrow[s] = !(mVal[s] == 0 && !mDnH[s][1]);
    end
  end

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    check("R11 low digit", int'(cntLo), mVal[0]);
    check("R11 high digit", int'(cntHi), mVal[1]);
    check("R1 binary count", int'(cntBin), mVal[2]);
    check("R7 carry low", int'(cLo), int'(mCarry[0]));
    check("R8 borrow low", int'(bLo), int'(mBorrow[0]));
    check("R7 carry high", int'(cHi), int'(mCarry[1]));
    check("R8 borrow high", int'(bHi), int'(mBorrow[1]));
    check("R7 carry binary", int'(cBin), int'(mCarry[2]));
    check("R8 borrow binary", int'(bBin), int'(mBorrow[2]));
  end

  task automatic setLine(input int which, input logic v);
    case (which)
      0: upLo = v;
      1: dnLo = v;
      2: upBin = v;
      default: dnBin = v;
    endcase
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); setLine(which, 1'b0);
      repeat (2) @(negedge clk);
      setLine(which, 1'b1);
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 reset low", int'(cntLo), 0);
    check("R10 reset bin", int'(cntBin), 0);
    check("R7 idle carry", int'(cLo), 1);
    check("R8 idle borrow", int'(bBin), 1);
    clr = 1'b0; binClr = 1'b0;
    repeat (3) @(negedge clk);

    // R5 / R11 counting up across a digit
    pulse(0, 12);
    check("R5 low after 12", int'(cntLo), 2);
    check("R11 high after 12", int'(cntHi), 1);

    // R3 falling edge and steady low do nothing; latency of three edges
    @(negedge clk); upBin = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 fall ignored", int'(cntBin), 0);
    upBin = 1'b1;
    @(negedge clk); check("R3 edge1", int'(cntBin), 0);
    @(negedge clk); check("R3 edge2", int'(cntBin), 0);
    @(negedge clk); check("R3 edge3", int'(cntBin), 1);
    repeat (3) @(negedge clk);

    // R1 / R7 binary wrap up
    pulse(2, 14);
    check("R1 at 15", int'(cntBin), 15);
    check("R7 carry high while up idle", int'(cBin), 1);
    upBin = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 carry low at top", int'(cBin), 0);
    upBin = 1'b1;
    @(negedge clk); check("R7 carry still low", int'(cBin), 0);
    @(negedge clk); check("R7 carry rises", int'(cBin), 1);
    check("R7 count before wrap", int'(cntBin), 15);
    @(negedge clk); check("R1 wrap to 0", int'(cntBin), 0);
    repeat (3) @(negedge clk);

    // R2 / R8 binary wrap down
    dnBin = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 borrow low at zero", int'(bBin), 0);
    dnBin = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 wrap to 15", int'(cntBin), 15);
    check("R8 borrow released", int'(bBin), 1);
    pulse(3, 2);
    check("R2 down two", int'(cntBin), 13);

    // R4 simultaneous edges hold
    @(negedge clk); upBin = 1'b0; dnBin = 1'b0;
    repeat (4) @(negedge clk);
    upBin = 1'b1; dnBin = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 hold", int'(cntBin), 13);

    // R9 load acts at once and masks pulses
    preLo = 4'd7; preHi = 4'd9;
    loadN = 1'b0;
    #1;
    check("R9 immediate low", int'(cntLo), 7);
    check("R9 immediate high", int'(cntHi), 9);
    pulse(0, 2);
    check("R9 pulses masked", int'(cntLo), 7);
    loadN = 1'b1;
    repeat (2) @(negedge clk);
    pulse(0, 3);
    check("R11 99 to 00 low", int'(cntLo), 0);
    check("R11 99 to 00 high", int'(cntHi), 0);

    // R11 / R5 down across 00
    pulse(1, 1);
    check("R5 down wrap low", int'(cntLo), 9);
    check("R11 down wrap high", int'(cntHi), 9);

    // R6 out-of-range preset in decade mode
    preLo = 4'd12; preHi = 4'd3;
    @(negedge clk); loadN = 1'b0;
    repeat (2) @(negedge clk); loadN = 1'b1;
    repeat (2) @(negedge clk);
    pulse(1, 1);
    check("R6 down from 12", int'(cntLo), 11);
    pulse(0, 1);
    check("R6 up from 11", int'(cntLo), 0);
    check("R6 no ripple", int'(cntHi), 3);

    // R10 clear overrides load, at once
    preLo = 4'd5; preHi = 4'd2;
    @(negedge clk); loadN = 1'b0; clr = 1'b1;
    #1;
    check("R10 clear over load", int'(cntLo), 0);
    check("R10 clear high", int'(cntHi), 0);
    repeat (2) @(negedge clk); clr = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 load after clear", int'(cntLo), 5);
    loadN = 1'b1;
    repeat (2) @(negedge clk);

    // long mixed runs against the reference
    pulse(0, 130);
    pulse(1, 70);
    for (int k = 0; k < 20; k++) begin
      pulse(k % 2, 3);
      pulse(2 + (k % 3 == 0 ? 1 : 0), 2);
    end
    check("R11 final low", int'(cntLo), mVal[0]);
    check("R11 final high", int'(cntHi), mVal[1]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule